// File: doc/BRIEF.md
# Fatal Error Fail-Code Reporter

This block sits next to a processor core and watches two groups of error flags. One group comes from the built-in self-test engines, one flag per tested unit. The other group comes from run-time checks. The block stays idle until the first clock edge at which any flag is high. At that edge it latches every flag and pulls its active-low failure pin low. It also asks the core to halt.

The block then reports the failure by issuing exactly one bus read. The address of that read is the whole message. The upper bits of the address carry a fixed prefix, and the low byte is a report code. Bit 7 of the report code is a mode bit that selects how bits 6..2 are read. The read request stays up with an unchanging address until the bus acknowledges it. After that the block stays silent and the core stays halted until reset.

Top module: `failcode_reporter`

## Requirements
- R1: While reset is held and right after it, fail_n is 1, halt_req is 0, and bus_valid and bus_rd are 0.
- R2: When any flag is high at a clock edge while the block is idle, fail_n is 0 and halt_req is 1 from that edge on. From the same edge, bus_valid and bus_rd are 1.
- R3: While bus_valid is 1, bus_addr[31:8] equals 0xFEFFFF and bus_addr[1:0] equals 0.
- R4: If any self-test flag was latched, the report is in self-test mode. bus_addr[7] is 1 and bus_addr[6:2] equals bist_fail[4:0]. The flag bits are bit 4 data RAM, bit 3 microcode ROM, bit 2 instruction cache, bit 1 data cache and bit 0 register cache or core.
- R5: If only run-time flags were latched, bus_addr[7] is 0, bus_addr[6:5] is 2'b11, and bus_addr[4:2] equals run_err[2:0]. The flag bits are bit 2 misaligned init structure, bit 1 system error in operation and bit 0 bus confidence failure.
- R6: When self-test and run-time flags are latched together, only the self-test report of R4 is issued, and the run-time flags do not appear in it.
- R7: The flags are latched at the edge at which the first one is seen. Later changes of any flag leave bus_addr unchanged.
- R8: While bus_valid is 1 and bus_rdy is 0, the request stays up and bus_addr is stable. The edge that samples bus_rdy high ends the request, and bus_valid is 0 after it.
- R9: After the acknowledge, no further request is issued until reset, whatever the flags and bus_rdy do. fail_n stays 0 and halt_req stays 1.
- R10: Reset returns the block to idle, and it reports a fresh failure afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_fail | input | 5 | Self-test failure flags, one per unit |
| run_err | input | 3 | Run-time error flags |
| bus_rdy | input | 1 | Bus acknowledge for the pending read |
| fail_n | output | 1 | Failure pin, low once a failure is detected |
| halt_req | output | 1 | Sticky halt request to the core |
| bus_addr | output | 32 | Read address carrying the fail code |
| bus_rd | output | 1 | Read strobe |
| bus_valid | output | 1 | Request valid |

## Verification
The bench raises flags in both modes and with both groups at once. A reporter that put the run-time report first, or mixed the two groups, would send the wrong mode bit. The bench then scrambles the flags while the read waits. A design that sampled the flags live would show a changing address. The bench also holds bus_rdy high before the failure and long after the acknowledge. A design that answered a stray acknowledge, or re-armed itself, would drop the request early or issue a second read.

// File: rtl/frc_pkg.sv
package frc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_DONE = 2'd2
   } frc_state_t;

   localparam int unsigned CODE_W  = 8;
   localparam int unsigned FIELD_W = 5;
   localparam int unsigned FIELD_LO = 2;
endpackage

// File: rtl/frc_capture.sv
module frc_capture #(
   parameter int unsigned N_BIST = 5,
   parameter int unsigned N_RUN  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic [N_BIST-1:0] bist_fail,
   input  logic [N_RUN-1:0]  run_err,
   output logic              hit,
   output logic [N_BIST-1:0] bist_q,
   output logic [N_RUN-1:0]  run_q
);
   assign hit = armed && ((|bist_fail) || (|run_err));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bist_q <= '0;
         run_q  <= '0;
      end else if (hit) begin
         bist_q <= bist_fail;
         run_q  <= run_err;
      end
   end
endmodule

// File: rtl/frc_encode.sv
module frc_encode
   import frc_pkg::*;
#(
   parameter int unsigned N_BIST        = 5,
   parameter int unsigned N_RUN         = 3,
   parameter bit          BIST_PRIORITY = 1'b1
) (
   input  logic [N_BIST-1:0] bist_q,
   input  logic [N_RUN-1:0]  run_q,
   output logic [CODE_W-1:0] code
);
   localparam int unsigned PAD_W = FIELD_W - N_RUN;

   logic [CODE_W-1:0] bist_code;
   logic [CODE_W-1:0] run_code;
   logic              use_bist;

   assign bist_code = {1'b1, bist_q, 2'b00};
   assign run_code  = {1'b0, {PAD_W{1'b1}}, run_q, 2'b00};

   generate
      if (BIST_PRIORITY) begin : g_bist_first
         assign use_bist = |bist_q;
      end else begin : g_run_first
         assign use_bist = ~(|run_q);
      end
   endgenerate

   assign code = use_bist ? bist_code : run_code;
endmodule

// File: rtl/frc_bus_master.sv
module frc_bus_master
   import frc_pkg::*;
#(
   parameter int unsigned      ADDR_W = 32,
   parameter logic [ADDR_W-9:0] PREFIX = 24'hFEFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [CODE_W-1:0] code,
   input  logic              bus_rdy,
   output logic              armed,
   output logic              fail_n,
   output logic              halt_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_valid
);
   frc_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (hit)     state_d = ST_REQ;
         ST_REQ:  if (bus_rdy) state_d = ST_DONE;
         ST_DONE: state_d = ST_DONE;
         default: state_d = ST_DONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign armed     = (state_q == ST_IDLE);
   assign fail_n    = (state_q == ST_IDLE);
   assign halt_req  = (state_q != ST_IDLE);
   assign bus_valid = (state_q == ST_REQ);
   assign bus_rd    = (state_q == ST_REQ);
   assign bus_addr  = {PREFIX, code};
endmodule

// File: rtl/failcode_reporter.sv
module failcode_reporter
   import frc_pkg::*;
#(
   parameter int unsigned       ADDR_W        = 32,
   parameter logic [ADDR_W-9:0] PREFIX        = 24'hFEFFFF,
   parameter int unsigned       N_BIST        = 5,
   parameter int unsigned       N_RUN         = 3,
   parameter bit                BIST_PRIORITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BIST-1:0] bist_fail,
   input  logic [N_RUN-1:0]  run_err,
   input  logic              bus_rdy,
   output logic              fail_n,
   output logic              halt_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_valid
);
   generate
      if (ADDR_W <= CODE_W) begin : g_bad_addr
         $fatal(1, "ADDR_W must exceed the code width");
      end
      if (N_BIST != FIELD_W) begin : g_bad_bist
         $fatal(1, "N_BIST must equal the mask field width");
      end
      if (N_RUN == 0 || N_RUN >= FIELD_W) begin : g_bad_run
         $fatal(1, "N_RUN must be between 1 and FIELD_W-1");
      end
   endgenerate

   logic              armed;
   logic              hit;
   logic [N_BIST-1:0] bist_q;
   logic [N_RUN-1:0]  run_q;
   logic [CODE_W-1:0] code;

   frc_capture #(.N_BIST(N_BIST), .N_RUN(N_RUN)) u_capture (
      .clk(clk), .rst_n(rst_n), .armed(armed),
      .bist_fail(bist_fail), .run_err(run_err),
      .hit(hit), .bist_q(bist_q), .run_q(run_q)
   );

   frc_encode #(.N_BIST(N_BIST), .N_RUN(N_RUN),
                .BIST_PRIORITY(BIST_PRIORITY)) u_encode (
      .bist_q(bist_q), .run_q(run_q), .code(code)
   );

   frc_bus_master #(.ADDR_W(ADDR_W), .PREFIX(PREFIX)) u_master (
      .clk(clk), .rst_n(rst_n), .hit(hit), .code(code), .bus_rdy(bus_rdy),
      .armed(armed), .fail_n(fail_n), .halt_req(halt_req),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_valid(bus_valid)
   );
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
   parameter int unsigned       ADDR_W = 32,
   parameter logic [ADDR_W-9:0] PREFIX = 24'hFEFFFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rdy,
   input logic              fail_n,
   input logic              halt_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_valid
);
   // R1: an idle block issues no request
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fail_n |-> (!bus_valid && !halt_req));

   // R2: a request always comes with a read strobe and a low failure pin
   p_req_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_rd && !fail_n && halt_req));

   p_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_addr[ADDR_W-1:8] == PREFIX && bus_addr[1:0] == 2'b00));

   p_run_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_addr[7]) |-> (bus_addr[6:5] == 2'b11));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_rdy) |=> (bus_valid && $stable(bus_addr)));

   p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_rdy) |=> !bus_valid);

   p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fail_n && !bus_valid) |=> !bus_valid);

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fail_n) |=> (!fail_n && halt_req));
endmodule

bind failcode_reporter frc_checker #(.ADDR_W(ADDR_W), .PREFIX(PREFIX)) u_frc_checker (
   .clk(clk), .rst_n(rst_n), .bus_rdy(bus_rdy), .fail_n(fail_n),
   .halt_req(halt_req), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_valid(bus_valid)
);

// File: tb/failcode_reporter_tb.sv
module failcode_reporter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bist_fail = '0;
   logic [2:0]  run_err = '0;
   logic        bus_rdy = 1'b0;
   logic        fail_n, halt_req, bus_rd, bus_valid;
   logic [31:0] bus_addr;

   int checks = 0;
   int errors = 0;
   int seed_dummy;

   always #5 clk = ~clk;

   failcode_reporter u_dut (
      .clk(clk), .rst_n(rst_n), .bist_fail(bist_fail), .run_err(run_err),
      .bus_rdy(bus_rdy), .fail_n(fail_n), .halt_req(halt_req),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_valid(bus_valid)
   );

   function automatic logic [31:0] exp_addr(logic [4:0] b, logic [2:0] r);
      if (b != 0) return {24'hFEFFFF, 1'b1, b, 2'b00};
      return {24'hFEFFFF, 1'b0, 2'b11, r, 2'b00};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bist_fail = '0; run_err = '0; bus_rdy = 1'b0;
      @(negedge clk);
      chk("R1", {fail_n, halt_req, bus_valid, bus_rd}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {fail_n, halt_req, bus_valid, bus_rd}, 4'b1000);
   endtask

   // one full failure episode; rdy_early holds bus_rdy high while idle
   task automatic episode(string req, logic [4:0] b, logic [2:0] r,
                          int idle, int waits, bit rdy_early);
      logic [31:0] e;
      e = exp_addr(b, r);
      bus_rdy = rdy_early;
      for (int i = 0; i < idle; i++) begin
         @(negedge clk);
         chk("R1", {fail_n, halt_req, bus_valid}, 3'b100);
      end
      bus_rdy = 1'b0;
      bist_fail = b; run_err = r;
      @(negedge clk);
      chk("R2", {fail_n, halt_req, bus_valid, bus_rd}, 4'b0111);
      chk(req, bus_addr, e);
      for (int i = 0; i < waits; i++) begin
         bist_fail = 5'($urandom); run_err = 3'($urandom);
         @(negedge clk);
         chk("R7", bus_addr, e);
         chk("R8", {31'd0, bus_valid}, 1);
      end
      bus_rdy = 1'b1;
      @(negedge clk);
      chk("R8", {31'd0, bus_valid}, 0);
      for (int i = 0; i < 6; i++) begin
         bus_rdy = 1'($urandom);
         bist_fail = 5'($urandom); run_err = 3'($urandom);
         @(negedge clk);
         chk("R9", {fail_n, halt_req, bus_valid, bus_rd}, 4'b0100);
      end
   endtask

   initial begin
      int n;
      seed_dummy = $urandom(32'h1F2E3D4C);
      repeat (2) @(negedge clk);
      do_reset();
      // directed corner cases
      episode("R4", 5'b10000, 3'b000, 2, 0, 1'b1);
      do_reset();
      episode("R4", 5'b00001, 3'b000, 0, 3, 1'b0);
      do_reset();
      episode("R5", 5'b00000, 3'b111, 1, 1, 1'b1);
      do_reset();
      episode("R5", 5'b00000, 3'b010, 3, 5, 1'b0);
      do_reset();
      episode("R6", 5'b01010, 3'b101, 1, 2, 1'b0);
      do_reset();
      episode("R10", 5'b11111, 3'b111, 0, 0, 1'b0);
      // constrained random episodes
      for (int k = 0; k < 60; k++) begin
         logic [4:0] b;
         logic [2:0] r;
         do_reset();
         n = int'($urandom % 3);
         b = (n == 0) ? 5'd0 : 5'($urandom);
         r = (n == 1) ? 3'd0 : 3'($urandom);
         if (b == 0 && r == 0) r = 3'b100;
         episode((b != 0 && r != 0) ? "R6" : (b != 0) ? "R4" : "R5",
                 b, r, int'($urandom % 4), int'($urandom % 5), 1'($urandom));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule